// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Re-arm Handling

This block turns an asynchronous serial line into characters. A free-running sixteen-times oversampling enable, `tick16`, paces it. It resynchronises the line and qualifies a start bit at its midpoint. It then samples each following bit at its centre. Each character is 5 to 8 data bits, sent least significant bit first, with an optional parity bit and one stop bit. The block delivers each character as a one-cycle strobe with the data byte and three flags: parity error, framing error and break.

Two line conditions get special handling. The first is a low stop bit on a non-zero character, which is a framing error. If the line is still low half a bit later, that moment counts as a fresh start edge, so a following character that starts at once is not lost. The second is a line held low through a whole character, stop bit included. That yields an all-zero character with the break flag set. Start search then stays blocked until the line has gone high again. Dropping the enable aborts any character in progress.

Top module: `uart_rx_brk`

## Requirements
- R1: While reset is high and in the first cycle after it, `vld_o` is 0 and `data_o`, `perr_o`, `ferr_o` and `brk_o` are all 0.
- R2: A low pulse that is gone when the line is resampled half a bit (8 ticks) after its falling edge is rejected, and no character is produced.
- R3: `cfg_len` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and land in `data_o[0]` upward, and bits above the selected count are 0.
- R4: `cfg_par` selects parity: 1 is even, 2 is odd, and 0 or 3 is none with no parity bit. `perr_o` is 1 exactly when the received data and parity bits break the selected rule.
- R5: A high stop bit gives `ferr_o`=0 and `brk_o`=0. The search for a start edge resumes right after the stop sample, so characters sent back to back are all received.
- R6: A low stop bit gives `ferr_o`=1 and `brk_o`=0 when any data bit or the parity bit was high.
- R7: After a framing error, a line still low half a bit past the stop sample is taken as a new start edge. The next character is then received with no extra falling edge.
- R8: A character whose data bits, parity bit and stop bit are all low gives `data_o`=0, `brk_o`=1 and `ferr_o`=0, once per break.
- R9: After a break, no new character begins until the synchronised line has been high on two consecutive clock edges. A line held low produces no further characters.
- R10: With `en` low, the receiver drops any partial character and produces nothing, and `vld_o` is 0 in the cycle after. After re-enabling, reception starts at the next falling edge.
- R11: `vld_o` is high for exactly one clock cycle per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Receiver enable |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line, asynchronous, idle high |
| cfg_len | input | 2 | Data bit count code (0..3 gives 5..8 bits) |
| cfg_par | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| vld_o | output | 1 | Character strobe, one cycle |
| data_o | output | 8 | Received character, upper unused bits 0 |
| perr_o | output | 1 | Parity error of this character |
| ferr_o | output | 1 | Framing error of this character |
| brk_o | output | 1 | Break detected |

## Verification
The assertions take for granted that `tick16` is a single-cycle pulse that recurs with at least several clocks between pulses. They also assume the line holds each bit for sixteen ticks, so a character lasts far longer than one clock. Under those conditions the one-cycle strobe and the held break state are meaningful. The stimulus keeps within this: it pulses `tick16` once every four clocks and holds every bit for exactly sixteen ticks. It changes `cfg_len` and `cfg_par` only while the line is idle, and releases the line high after every low stop bit except in the re-arm and break scenarios, which depend on it staying low.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_REARM, ST_BRKW
  } rx_st_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);
  // one extra stage holds the previous synchronised value for edge detection
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign dout = sr[STAGES-1];
  assign fall = sr[STAGES] & ~sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import urx_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OS  = OSR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic          fall,
  input  logic [1:0]    cfg_len,
  input  logic [1:0]    cfg_par,
  output logic          vld_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o
);
  localparam int CW   = $clog2(OS);
  localparam int HALF = OS / 2;
  localparam int NBW  = $clog2(DW) + 1;

  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [NBW-1:0] nb_l, bidx;
  par_e          par_l;
  logic [DW-1:0] sh, shv;
  logic          pbit, hcnt, perr_c;

  wire at_half = tick && (cnt == CW'(HALF - 1));
  wire at_bit  = tick && (cnt == CW'(OS - 1));
  wire use_par = (par_l == PAR_EVEN) || (par_l == PAR_ODD);

  always_comb begin
    shv    = sh >> (NBW'(DW) - nb_l);
    perr_c = 1'b0;
    if (par_l == PAR_EVEN) perr_c = ^shv ^ pbit;
    if (par_l == PAR_ODD)  perr_c = ~(^shv ^ pbit);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st <= ST_IDLE; cnt <= '0; bidx <= '0; pbit <= 1'b0; hcnt <= 1'b0;
      vld_o <= 1'b0;
      if (rst) begin
        sh <= '0; nb_l <= NBW'(DW); par_l <= PAR_NONE;
        data_o <= '0; perr_o <= 1'b0; ferr_o <= 1'b0; brk_o <= 1'b0;
      end
    end else begin
      vld_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (fall) begin
            st    <= ST_START;
            nb_l  <= NBW'(cfg_len) + NBW'(5);
            par_l <= par_e'(cfg_par);
          end
        end
        ST_START: if (tick) begin
          if (at_half) begin
            cnt <= '0; bidx <= '0; pbit <= 1'b0;
            st  <= rxd ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick) begin
          cnt <= cnt + 1'b1;
          if (at_bit) begin
            sh <= {rxd, sh[DW-1:1]};
            if (bidx == nb_l - 1'b1) st <= use_par ? ST_PAR : ST_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        ST_PAR: if (tick) begin
          cnt <= cnt + 1'b1;
          if (at_bit) begin pbit <= rxd; st <= ST_STOP; end
        end
        ST_STOP: if (tick) begin
          cnt <= cnt + 1'b1;
          if (at_bit) begin
            cnt    <= '0;
            vld_o  <= 1'b1;
            perr_o <= perr_c;
            if (rxd) begin
              data_o <= shv; ferr_o <= 1'b0; brk_o <= 1'b0; st <= ST_IDLE;
            end else if (shv == '0 && !pbit) begin
              data_o <= '0; ferr_o <= 1'b0; brk_o <= 1'b1; st <= ST_BRKW;
              hcnt   <= 1'b0;
            end else begin
              data_o <= shv; ferr_o <= 1'b1; brk_o <= 1'b0; st <= ST_REARM;
            end
          end
        end
        ST_REARM: if (tick) begin
          if (at_half) begin
            cnt <= '0;
            st  <= rxd ? ST_IDLE : ST_START;
          end else cnt <= cnt + 1'b1;
        end
        ST_BRKW: begin
          if (rxd) begin
            hcnt <= 1'b1;
            if (hcnt) st <= ST_IDLE;
          end else hcnt <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |=> !vld_o);
  // R8
  brk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_o && brk_o) |-> (data_o == '0 && !ferr_o));
  // R9
  brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRKW && !rxd && en) |=> (st == ST_BRKW));
  // R10
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !vld_o);
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ((data_o >> nb_l) == '0));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import urx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_par,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  logic rx_s, rx_fall;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rx_s), .fall(rx_fall)
  );

  rx_frame #(.DW(DATA_W), .OS(OSR)) u_frame (
    .clk(clk), .rst(rst), .en(en), .tick(tick16), .rxd(rx_s), .fall(rx_fall),
    .cfg_len(cfg_len), .cfg_par(cfg_par),
    .vld_o(vld_o), .data_o(data_o), .perr_o(perr_o), .ferr_o(ferr_o),
    .brk_o(brk_o)
  );

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> !(ferr_o && brk_o));
endmodule

// File: tb/sim_uart_rx_brk.sv
`timescale 1ns/1ps
module sim_uart_rx_brk;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic vld_o, perr_o, ferr_o, brk_o;
  logic [7:0] data_o;
  int errs = 0, checks = 0, vcnt = 0;
  logic [1:0] tdiv = '0;
  logic [7:0] cap_d [64];
  logic       cap_p [64], cap_f [64], cap_b [64];

  localparam int BIT = 64;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(negedge clk) if (vld_o && vcnt < 64) begin
    cap_d[vcnt] = data_o; cap_p[vcnt] = perr_o;
    cap_f[vcnt] = ferr_o; cap_b[vcnt] = brk_o;
    vcnt++;
  end

  uart_rx_brk u0 (.clk(clk), .rst(rst), .en(en), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .vld_o(vld_o), .data_o(data_o),
    .perr_o(perr_o), .ferr_o(ferr_o), .brk_o(brk_o));

  // {len[13:12], par[11:10], data[9:2], bad parity[1], stop[0]}
  localparam logic [13:0] VEC [10] = '{
    {2'd3, 2'd0, 8'hA5, 1'b0, 1'b1},
    {2'd0, 2'd0, 8'hFF, 1'b0, 1'b1},
    {2'd1, 2'd1, 8'h2D, 1'b0, 1'b1},
    {2'd2, 2'd2, 8'h55, 1'b0, 1'b1},
    {2'd3, 2'd1, 8'h81, 1'b1, 1'b1},
    {2'd3, 2'd2, 8'h00, 1'b1, 1'b1},
    {2'd3, 2'd3, 8'h3C, 1'b1, 1'b1},
    {2'd3, 2'd0, 8'h5A, 1'b0, 1'b0},
    {2'd3, 2'd0, 8'h00, 1'b0, 1'b0},
    {2'd2, 2'd1, 8'h80, 1'b0, 1'b0}
  };

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    rxd <= b;
    repeat (BIT) @(posedge clk);
  endtask

  function automatic logic par_bit(int len, int par, logic [7:0] d, bit badp);
    logic [7:0] m = 8'((1 << (len + 5)) - 1);
    logic p = ^(d & m);
    if (par == 2) p = ~p;
    if (badp) p = ~p;
    return p;
  endfunction

  task automatic send(int len, int par, logic [7:0] d, bit badp, bit stopb);
    @(posedge clk);
    cfg_len <= 2'(len); cfg_par <= 2'(par);
    sbit(1'b0);
    for (int i = 0; i < len + 5; i++) sbit(d[i]);
    if (par == 1 || par == 2) sbit(par_bit(len, par, d, badp));
    sbit(stopb);
  endtask

  task automatic idle(int bits);
    rxd <= 1'b1;
    repeat (bits * BIT) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2_000_000 / 10) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!vld_o && data_o == 0 && !perr_o && !ferr_o && !brk_o, "R1 reset",
        {vld_o, perr_o, ferr_o, brk_o, data_o}, 0);
    @(posedge clk); rst <= 1'b0; en <= 1'b1;
    @(negedge clk);
    chk(!vld_o && data_o == 0, "R1 after reset", {vld_o, data_o}, 0);
    idle(2);

    for (int r = 0; r < 10; r++) begin
      int len, par; logic [7:0] d, m; bit badp, stopb; logic pb;
      logic ep, ef, eb;
      len = VEC[r][13:12]; par = VEC[r][11:10]; d = VEC[r][9:2];
      badp = VEC[r][1]; stopb = VEC[r][0];
      m = 8'((1 << (len + 5)) - 1);
      pb = (par == 1 || par == 2) ? par_bit(len, par, d, badp) : 1'b0;
      ep = badp && (par == 1 || par == 2);
      eb = !stopb && (d & m) == 0 && !pb;
      ef = !stopb && !eb;
      base = vcnt;
      send(len, par, d, badp, stopb);
      idle(2);
      chk(vcnt == base + 1, "R11 one strobe per char", vcnt - base, 1);
      chk(cap_d[base] == (eb ? 8'h00 : (d & m)), "R3 data", cap_d[base],
          eb ? 0 : (d & m));
      chk(cap_p[base] == ep, "R4 parity flag", cap_p[base], ep);
      chk(cap_f[base] == ef, "R6 framing flag", cap_f[base], ef);
      chk(cap_b[base] == eb, "R8 break flag", cap_b[base], eb);
    end

    // R2 short glitch rejected
    base = vcnt;
    @(posedge clk); rxd <= 1'b0;
    repeat (16) @(posedge clk);
    idle(3);
    chk(vcnt == base, "R2 glitch rejected", vcnt - base, 0);

    // R5 back-to-back characters
    base = vcnt;
    send(3, 0, 8'h12, 0, 1);
    send(3, 0, 8'h34, 0, 1);
    idle(2);
    chk(vcnt == base + 2, "R5 back-to-back count", vcnt - base, 2);
    chk(cap_d[base] == 8'h12 && cap_d[base+1] == 8'h34 && !cap_f[base+1],
        "R5 back-to-back data", {cap_d[base], cap_d[base+1]}, 16'h1234);

    // R7 re-arm after framing error with line still low
    base = vcnt;
    send(3, 0, 8'h5A, 0, 0);
    send(3, 0, 8'hC3, 0, 1);
    idle(2);
    chk(vcnt == base + 2, "R7 re-arm count", vcnt - base, 2);
    chk(cap_f[base] && cap_d[base] == 8'h5A, "R7 first char framing",
        {cap_f[base], cap_d[base]}, 9'h15A);
    chk(cap_d[base+1] == 8'hC3 && !cap_f[base+1], "R7 second char",
        {cap_f[base+1], cap_d[base+1]}, 9'h0C3);

    // R9 break then line held low: a single character only
    base = vcnt;
    cfg_len <= 2'd3; cfg_par <= 2'd0;
    @(posedge clk); rxd <= 1'b0;
    repeat (25 * BIT) @(posedge clk);
    @(negedge clk);
    chk(vcnt == base + 1 && cap_b[base], "R9 held break single char",
        vcnt - base, 1);
    idle(2);
    send(3, 0, 8'h6E, 0, 1);
    idle(2);
    chk(vcnt == base + 2 && cap_d[base+1] == 8'h6E, "R9 receive after break",
        cap_d[base+1], 8'h6E);

    // R10 disable mid-character
    base = vcnt;
    @(posedge clk); cfg_len <= 2'd3; cfg_par <= 2'd0;
    sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    @(posedge clk); en <= 1'b0;
    rxd <= 1'b1;
    repeat (2 * BIT) @(posedge clk);
    @(negedge clk);
    chk(vcnt == base && !vld_o, "R10 no output while disabled", vcnt - base, 0);
    @(posedge clk); en <= 1'b1;
    idle(1);
    send(3, 0, 8'h99, 0, 1);
    idle(2);
    chk(vcnt == base + 1 && cap_d[base] == 8'h99, "R10 resume after enable",
        cap_d[base], 8'h99);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule